// File: doc/BRIEF.md
# Periodic Stream Marker Inserter

This block sits between a streaming source, such as the read side of a DMA channel, and a consumer that draws one 32-bit beat on every cycle it signals ready. Both sides use valid/ready handshakes in the AXI4-Stream style. A free-running beat counter divides the output into periods of fixed length. The first beat of every period is a constant 32-bit marker word. The remaining beats carry source data when the source offers it, and zero filler when it does not. The output therefore keeps a constant rate, and the markers land at fixed positions whether or not data is flowing.

While the marker beat is on the output, the ready returned to the source is held low, so a word the source offers in that cycle stays where it is and goes out in the next slot. Outside the marker slot the consumer's ready passes straight through to the source. Each source beat is taken exactly once: on a cycle where the source's valid and the gated ready are both high. A burst therefore appears on the output complete and in order, with markers placed around it or inside it and no word repeated or lost.

The period (default 1024 beats, i.e. one 4-byte marker per 4096 output bytes) and the marker value are parameters. A synchronous active-high reset puts the counter back on the marker slot.

Top module: `stream_marker_inserter`

## Requirements
- R1: While reset is high, out_valid and src_ready are both 0. The first output beat after reset is released is the marker.
- R2: Output beats are counted on cycles where out_valid and out_ready are both high. Beat number k (counting from 0 after reset) is the marker word MARKER exactly when k mod PERIOD_BEATS is 0.
- R3: Markers appear at the R2 positions even when src_valid stays low for whole periods.
- R4: src_ready is 0 in every cycle where the current slot is a marker slot.
- R5: In every non-marker slot after reset, src_ready equals out_ready.
- R6: In a non-marker slot where src_valid is 0, out_data is 32'h0000_0000.
- R7: In a non-marker slot where src_valid is 1, out_data equals src_data. A source beat is taken only when src_valid and src_ready are both high. The taken beats come out in order, with none repeated or lost.
- R8: A cycle with out_ready low does not advance the slot counter. The same slot, and its marker or data decision, is still current in the next cycle.
- R9: out_valid is 1 in every cycle after reset is released.
- R10: A reset asserted in the middle of a period restarts the period, so the first beat after release is the marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_data | input | 32 | Source beat (16-bit I and 16-bit Q) |
| src_valid | input | 1 | Source offers a beat |
| src_ready | output | 1 | Gated ready to the source, low during the marker slot |
| out_data | output | 32 | Output beat: marker, source data or zero filler |
| out_valid | output | 1 | Output beat present, high whenever out of reset |
| out_ready | input | 1 | Consumer accepts the output beat |

## Verification
The assertions assume that the source keeps src_data stable while it holds src_valid high and waits for a handshake. They also assume that reset is held across at least one rising edge. The source model in the bench offers a new word only after the previous one has been taken, and it leaves that word unchanged until then. The bench asserts reset for several whole cycles, once at start-up and once in the middle of a period. Gaps in src_valid and out_ready come from a bench LFSR, so stalls fall on marker slots, on data slots and on the slot just before a period wraps.

// File: rtl/mkins_pkg.sv
package mkins_pkg;

  typedef enum logic [1:0] {
    SLOT_MARK = 2'd0,
    SLOT_DATA = 2'd1,
    SLOT_FILL = 2'd2
  } slot_kind_e;

  // Slot index zero of every period carries the marker.
  function automatic logic idx_is_marker(input int unsigned idx);
    return (idx == 0);
  endfunction

  // Next slot index, wrapping at the period length.
  function automatic int unsigned idx_next(input int unsigned idx,
                                           input int unsigned period);
    return (idx + 1 >= period) ? 0 : idx + 1;
  endfunction

  // Classify the current output slot.
  function automatic slot_kind_e classify(input logic marker, input logic have_src);
    if (marker)        return SLOT_MARK;
    else if (have_src) return SLOT_DATA;
    else               return SLOT_FILL;
  endfunction

endpackage

// File: rtl/mkins_slot_counter.sv
module mkins_slot_counter
  import mkins_pkg::*;
#(
  parameter int unsigned PERIOD_BEATS = 1024,
  localparam int unsigned CW = (PERIOD_BEATS > 2) ? $clog2(PERIOD_BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  output logic [CW-1:0] slot_idx,
  output logic          marker_slot,
  output logic          wrap_evt
);

  localparam logic [CW-1:0] LAST_IDX = CW'(PERIOD_BEATS - 1);

  logic [CW-1:0] idx_q;
  logic [CW-1:0] idx_d;

  always_comb begin
    idx_d = CW'(idx_next(int'(idx_q), PERIOD_BEATS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (advance) begin
      idx_q <= idx_d;
    end
  end

  assign slot_idx    = idx_q;
  assign marker_slot = idx_is_marker(int'(idx_q));
  assign wrap_evt    = advance && (idx_q == LAST_IDX);

  // R2: the last slot of a period is followed by the marker slot
  p_wrap_to_marker_r2: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> (slot_idx == '0));

  // R2: inside a period, an accepted beat moves to the next slot
  p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
    (advance && slot_idx != LAST_IDX) |=> (slot_idx == $past(slot_idx) + CW'(1)));

  // R8: a stalled cycle keeps the slot
  p_hold_when_stalled_r8: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(slot_idx));

endmodule

// File: rtl/mkins_ready_gate.sv
module mkins_ready_gate (
  input  logic clk,
  input  logic rst,
  input  logic marker_slot,
  input  logic out_ready,
  input  logic src_valid,
  output logic src_ready,
  output logic take_evt
);

  assign src_ready = !rst && !marker_slot && out_ready;
  assign take_evt  = src_valid && src_ready;

  // R4: the source is never offered ready in the marker slot
  p_gate_marker_r4: assert property (@(posedge clk) disable iff (rst)
    marker_slot |-> !src_ready);

  // R5: outside the marker slot the consumer ready reaches the source
  p_pass_ready_r5: assert property (@(posedge clk) disable iff (rst)
    !marker_slot |-> (src_ready == out_ready));

  // R7: a take never happens in the marker slot
  p_no_take_in_marker_r7: assert property (@(posedge clk) disable iff (rst)
    marker_slot |-> !take_evt);

endmodule

// File: rtl/mkins_beat_mux.sv
module mkins_beat_mux
  import mkins_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] MARKER = 32'hC0DE_F00D
) (
  input  logic              marker_slot,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output slot_kind_e        kind,
  output logic [DATA_W-1:0] out_data
);

  always_comb begin
    kind = classify(marker_slot, src_valid);
    unique case (kind)
      SLOT_MARK: out_data = MARKER;
      SLOT_DATA: out_data = src_data;
      default:   out_data = '0;
    endcase
  end

endmodule

// File: rtl/stream_marker_inserter.sv
module stream_marker_inserter
  import mkins_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned PERIOD_BEATS = 1024,
  parameter logic [DATA_W-1:0] MARKER = 32'hC0DE_F00D,
  localparam int unsigned CW = (PERIOD_BEATS > 2) ? $clog2(PERIOD_BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready
);

  logic          advance;
  logic [CW-1:0] slot_idx;
  logic          marker_slot;
  logic          wrap_evt;
  logic          take_evt;
  slot_kind_e    kind;
  logic          rst_q;

  assign out_valid = !rst;
  assign advance   = out_valid && out_ready;

  mkins_slot_counter #(.PERIOD_BEATS(PERIOD_BEATS)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .advance     (advance),
    .slot_idx    (slot_idx),
    .marker_slot (marker_slot),
    .wrap_evt    (wrap_evt)
  );

  mkins_ready_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .marker_slot (marker_slot),
    .out_ready   (out_ready),
    .src_valid   (src_valid),
    .src_ready   (src_ready),
    .take_evt    (take_evt)
  );

  mkins_beat_mux #(.DATA_W(DATA_W), .MARKER(MARKER)) u_mux (
    .marker_slot (marker_slot),
    .src_valid   (src_valid),
    .src_data    (src_data),
    .kind        (kind),
    .out_data    (out_data)
  );

  always_ff @(posedge clk) begin
    rst_q <= rst;
  end

  // R1: the first slot after reset release is the marker
  p_marker_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (marker_slot && out_data == MARKER));

  // R2: the marker slot carries the marker word
  p_marker_word_r2: assert property (@(posedge clk) disable iff (rst)
    (kind == SLOT_MARK) |-> (out_data == MARKER && slot_idx == '0));

  // R6: idle data slots carry zero filler
  p_fill_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (!marker_slot && !src_valid) |-> (out_data == '0));

  // R7: a taken beat is the beat on the output
  p_take_matches_r7: assert property (@(posedge clk) disable iff (rst)
    take_evt |-> (out_data == src_data && advance));

  // R9: output valid stays high out of reset
  p_valid_high_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid);

  // R2: a period wrap is followed by a marker slot
  p_wrap_marker_r2: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> marker_slot);

endmodule

// File: tb/stream_marker_inserter_bench.sv
`timescale 1ns/1ps
module stream_marker_inserter_bench;

  localparam int unsigned P      = 32;
  localparam logic [31:0] MARK   = 32'hC0DE_F00D;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] src_data;
  logic        src_valid;
  logic        src_ready;
  logic [31:0] out_data;
  logic        out_valid;
  logic        out_ready;

  always #2.5 clk = ~clk;

  stream_marker_inserter #(.DATA_W(32), .PERIOD_BEATS(P), .MARKER(MARK)) u_stream_marker_inserter (
    .clk(clk), .rst(rst), .src_data(src_data), .src_valid(src_valid),
    .src_ready(src_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready)
  );

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  int unsigned slot = 0;
  logic took = 1'b0;
  logic first_after_rst = 1'b0;
  int pushed = 0;
  int popped = 0;
  int idle_markers = 0;
  int items_left = 0;
  int src_mode = 0;   // 0 idle, 1 always offer, 2 gated
  int rdy_mode = 0;   // 0 always ready, 1 gated
  logic [15:0] lfsr = 16'hACE1;
  logic pending = 1'b0;
  logic idle_phase = 1'b0;
  logic done = 1'b0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor / scoreboard, away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      took = 1'b0;
      if (rst) begin
        check(out_valid == 1'b0, "R1 out_valid in reset", {31'b0, out_valid}, 32'h0);
        check(src_ready == 1'b0, "R1 src_ready in reset", {31'b0, src_ready}, 32'h0);
        slot = 0;
        first_after_rst = 1'b1;
      end else begin
        check(out_valid == 1'b1, "R9 out_valid high", {31'b0, out_valid}, 32'h1);
        if (slot == 0) begin
          check(out_data == MARK, first_after_rst ? "R1/R10 first beat marker" : "R2 marker slot",
                out_data, MARK);
          check(src_ready == 1'b0, "R4 ready gated in marker", {31'b0, src_ready}, 32'h0);
          if (idle_phase && out_ready) idle_markers++;
        end else begin
          check(src_ready == out_ready, "R5 ready pass-through", {31'b0, src_ready}, {31'b0, out_ready});
          if (src_valid)
            check(out_data == src_data, "R7 data passed", out_data, src_data);
          else
            check(out_data == 32'h0, idle_phase ? "R3/R6 idle filler" : "R6 zero filler", out_data, 32'h0);
          if (src_valid && src_ready) begin
            took = 1'b1;
            if (exp_q.size() == 0) begin
              check(1'b0, "R7 unexpected extra beat", out_data, 32'h0);
            end else begin
              check(out_data == exp_q[0], "R7 order no dup/drop", out_data, exp_q[0]);
              void'(exp_q.pop_front());
              popped++;
            end
          end
        end
        if (out_ready) begin
          slot = (slot + 1 >= P) ? 0 : slot + 1;
          first_after_rst = 1'b0;
        end
      end
    end
  end

  // Source and consumer driver
  initial begin
    src_valid = 1'b0;
    src_data  = 32'h0;
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (took) begin
        pending = 1'b0;
        src_valid = 1'b0;
        src_data = 32'h0;
      end
      if (!pending && items_left > 0 &&
          (src_mode == 1 || (src_mode == 2 && lfsr[0]))) begin
        src_data = 32'h5A00_0000 + 32'(pushed);
        exp_q.push_back(src_data);
        pushed++;
        items_left--;
        pending = 1'b1;
        src_valid = 1'b1;
      end
      out_ready = (rdy_mode == 1) ? (lfsr[3] | lfsr[7]) : 1'b1;
    end
  end

  task automatic wait_drain(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(posedge clk);
      if (items_left == 0 && !pending && exp_q.size() == 0) break;
    end
  endtask

  // Watchdog
  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R3 / R6: idle stream for several periods
    idle_phase = 1'b1;
    repeat (3 * P + 5) @(posedge clk);
    idle_phase = 1'b0;
    check(idle_markers >= 3, "R3 markers while idle", 32'(idle_markers), 32'd3);

    // R7: back-to-back burst crossing markers
    src_mode = 1; items_left = 64;
    wait_drain(2000);

    // R7 / R8: gated source and stalling consumer
    src_mode = 2; rdy_mode = 1; items_left = 200;
    wait_drain(20000);

    // R10: reset in the middle of a period
    src_mode = 1; rdy_mode = 0; items_left = 20;
    while (slot != 7) @(negedge clk);
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    wait_drain(2000);

    // R8: heavy stalls across wraps
    src_mode = 2; rdy_mode = 1; items_left = 150;
    wait_drain(20000);
    repeat (5) @(posedge clk);

    check(exp_q.size() == 0, "R7 all beats delivered", 32'(exp_q.size()), 32'h0);
    check(popped == pushed, "R7 beat count", 32'(popped), 32'(pushed));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule